// File: doc/BRIEF.md
# Self-Synchronizing PRBS Error Detector

This block sits at the receive end of a bit-error-rate test link. Each received bit arrives with a one-cycle strobe and is shifted into a 24-stage history register. Two selectable taps of that history are XORed to predict the bit that should arrive next. The history is loaded from the received data rather than from the block's own feedback, so the block locks onto any stream from a matching generator without seeding. A bit that does not equal its prediction raises a one-cycle mismatch flag.

Because the history holds received bits, one corrupted bit on the channel is seen three times: once when it arrives, and once more as it reaches each of the two taps. A divide-by-three stage turns each such burst into one error pulse. Two saturating counters, one for bits and one for errors, give the raw numbers for a bit error ratio. They are wide enough to resolve ratios from 1e-3 down to 1e-8.

Comparison is held off while the history fills. This happens after reset and after any change of the tap selection. A tap change also restarts the divider. The lock controller has two states: LK_FILL and LK_TRACK. The 24th strobe after a restart moves it from LK_FILL to LK_TRACK. A tap change sends it from either state back to LK_FILL. The divider has three phases: DV_ZERO, DV_ONE and DV_TWO. Each qualified mismatch advances it one phase. A mismatch taken in DV_TWO returns it to DV_ZERO and emits the error event. A tap change forces it to DV_ZERO.

Top module: `prbs_err_detector`

## Requirements
- R1: While reset is low, and in the first cycle after it, `mism` and `err_pulse` are 0 and both counters read 0. The lock controller starts in LK_FILL and the divider starts in DV_ZERO.
- R2: Tap value t selects the bit received t strobes before the current one. A tap value of 0 acts as 1, and a value above 24 acts as 24. On a strobe in LK_TRACK, `mism` is 1 in the following cycle exactly when `bit_in` differs from the XOR of the two selected bits, and 0 otherwise.
- R3: The first 24 strobes after reset, or after a cycle in which either tap input differs from its previous value, are never flagged. The 25th strobe is compared. A strobe in the tap-change cycle itself is not counted toward the 24.
- R4: One corrupted bit in a stream from a matching generator with distinct taps gives exactly three mismatches. `err_pulse` is 1 for one cycle, together with the third mismatch, and `err_cnt` rises by one in that same cycle.
- R5: A tap change returns the divide-by-three stage to DV_ZERO. A mismatch count left over from before the change cannot shorten the next group of three.
- R6: `bit_cnt` rises by one in the cycle after every strobe, including strobes during fill. It stops at its all-ones value.
- R7: `err_cnt` rises once per `err_pulse` and stops at its all-ones value.
- R8: `cnt_clr` zeroes both counters in the next cycle. It takes priority over a coincident bit or error increment, and it does not suppress a coincident `err_pulse`.
- R9: Cycles without a strobe change nothing. `mism` stays 0, the counters hold, and the history is not disturbed, whatever `bit_in` does.
- R10: Once filled, a stream from a generator that uses the same taps yields no mismatch, whatever state the generator started from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received serial data |
| tap_a | input | TAP_W (5) | First feedback tap, 1..24 |
| tap_b | input | TAP_W (5) | Second feedback tap, 1..24 |
| cnt_clr | input | 1 | Zero both counters |
| mism | output | 1 | Raw mismatch flag, one cycle per flagged bit |
| err_pulse | output | 1 | One pulse per three mismatches (one channel error) |
| bit_cnt | output | CNT_W (32) | Saturating count of received bits |
| err_cnt | output | CNT_W (32) | Saturating count of error pulses |

## Verification
The counter clear and the counter increments can land in the same cycle. This covers both a bit strobe and the third mismatch of a group. The bench places an error so that its last tap crossing falls exactly on a strobe that also carries `cnt_clr`. It then expects `err_pulse` high, with both counters at zero rather than one. A tap change in the middle of a group is also exercised: after the restart, the following error must still need three full mismatches before its pulse appears.

// File: rtl/prbs_det_pkg.sv
package prbs_det_pkg;

    // Default history length and tap-field width.
    localparam int unsigned DEF_SR_LEN = 24;
    localparam int unsigned DEF_TAP_W  = 5;
    localparam int unsigned DEF_CNT_W  = 32;

    // Lock controller: filling the history, or comparing.
    typedef enum logic {
        LK_FILL  = 1'b0,
        LK_TRACK = 1'b1
    } lock_st_e;

    // Divide-by-three phases for mismatch grouping.
    typedef enum logic [1:0] {
        DV_ZERO = 2'd0,
        DV_ONE  = 2'd1,
        DV_TWO  = 2'd2
    } div_st_e;

endpackage

// File: rtl/prbs_ref_shift.sv
// History of received bits plus tap selection; emits the predicted bit.
module prbs_ref_shift #(
    parameter int unsigned SR_LEN = 24,
    parameter int unsigned TAP_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic [TAP_W-1:0] tap_a_i,
    input  logic [TAP_W-1:0] tap_b_i,
    output logic             pred_o
);

    localparam int unsigned IDX_W = $clog2(SR_LEN);
    localparam int unsigned N_TAP = 2;

    logic [SR_LEN-1:0] stages;
    logic [TAP_W-1:0]  sel_tap [N_TAP];
    logic [N_TAP-1:0]  tap_bit;

    assign sel_tap[0] = tap_a_i;
    assign sel_tap[1] = tap_b_i;

    // stages[0] holds the bit received one strobe ago.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else if (shift_i) begin
            stages <= {stages[SR_LEN-2:0], bit_i};
        end
    end

    // One selector per tap; out-of-range values clamp to the ends.
    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        logic [IDX_W-1:0] idx;
        always_comb begin
            if (sel_tap[g] == '0) begin
                idx = '0;
            end else if (int'(sel_tap[g]) > int'(SR_LEN)) begin
                idx = IDX_W'(SR_LEN - 1);
            end else begin
                idx = IDX_W'(sel_tap[g] - 1'b1);
            end
        end
        assign tap_bit[g] = stages[idx];
    end

    assign pred_o = ^tap_bit;

endmodule

// File: rtl/prbs_lock_fsm.sv
// Holds off comparison until the history holds SR_LEN received bits.
module prbs_lock_fsm
    import prbs_det_pkg::*;
#(
    parameter int unsigned SR_LEN = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic tap_chg_i,
    output logic track_o
);

    localparam int unsigned FILL_W = $clog2(SR_LEN + 1);
    localparam logic [FILL_W-1:0] LAST_FILL = FILL_W'(SR_LEN - 1);

    lock_st_e          st_q, st_n;
    logic [FILL_W-1:0] fill_q, fill_n;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LK_FILL;
            fill_q <= '0;
        end else begin
            st_q   <= st_n;
            fill_q <= fill_n;
        end
    end

    // Transitions: FILL->TRACK on the last fill strobe, any->FILL on tap change.
    always_comb begin
        st_n   = st_q;
        fill_n = fill_q;
        if (tap_chg_i) begin
            st_n   = LK_FILL;
            fill_n = '0;
        end else begin
            unique case (st_q)
                LK_FILL: begin
                    if (strobe_i) begin
                        fill_n = fill_q + 1'b1;
                        if (fill_q == LAST_FILL) begin
                            st_n = LK_TRACK;
                        end
                    end
                end
                LK_TRACK: begin
                    st_n = LK_TRACK;
                end
                default: begin
                    st_n   = LK_FILL;
                    fill_n = '0;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        track_o = (st_q == LK_TRACK) && !tap_chg_i;
    end

    AST_FILL_AFTER_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        tap_chg_i |=> !track_o);  // R3

endmodule

// File: rtl/prbs_err_div3.sv
// Groups qualified mismatches by three; one event per group.
module prbs_err_div3
    import prbs_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic hit_i,
    output logic event_o,
    output logic pulse_o
);

    div_st_e st_q, st_n;
    logic    pulse_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= DV_ZERO;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            pulse_q <= event_o;
        end
    end

    // Transitions: ZERO->ONE->TWO->ZERO per hit; clear forces ZERO.
    always_comb begin
        st_n = st_q;
        if (clr_i) begin
            st_n = DV_ZERO;
        end else if (hit_i) begin
            unique case (st_q)
                DV_ZERO: st_n = DV_ONE;
                DV_ONE:  st_n = DV_TWO;
                DV_TWO:  st_n = DV_ZERO;
                default: st_n = DV_ZERO;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        event_o = hit_i && !clr_i && (st_q == DV_TWO);
        pulse_o = pulse_q;
    end

    AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);  // R4

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q == DV_ZERO));  // R5

endmodule

// File: rtl/prbs_sat_cnt.sv
// Saturating up-counter with synchronous clear (clear wins).
module prbs_sat_cnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));  // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));  // R7

endmodule

// File: rtl/prbs_err_detector.sv
module prbs_err_detector
    import prbs_det_pkg::*;
#(
    parameter int unsigned SR_LEN = DEF_SR_LEN,
    parameter int unsigned TAP_W  = DEF_TAP_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic [TAP_W-1:0] tap_a,
    input  logic [TAP_W-1:0] tap_b,
    input  logic             cnt_clr,
    output logic             mism,
    output logic             err_pulse,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CNT_W-1:0] err_cnt
);

    logic [TAP_W-1:0] tap_a_q, tap_b_q;
    logic             tap_chg;
    logic             pred;
    logic             track;
    logic             hit;
    logic             err_event;
    logic             mism_q;

    // Remember the taps to detect a change; reset captures the current ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_a_q <= tap_a;
            tap_b_q <= tap_b;
        end else begin
            tap_a_q <= tap_a;
            tap_b_q <= tap_b;
        end
    end

    assign tap_chg = (tap_a != tap_a_q) || (tap_b != tap_b_q);

    prbs_ref_shift #(.SR_LEN(SR_LEN), .TAP_W(TAP_W)) ref_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (bit_vld),
        .bit_i   (bit_in),
        .tap_a_i (tap_a),
        .tap_b_i (tap_b),
        .pred_o  (pred)
    );

    prbs_lock_fsm #(.SR_LEN(SR_LEN)) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (bit_vld),
        .tap_chg_i (tap_chg),
        .track_o   (track)
    );

    assign hit = bit_vld && track && (bit_in ^ pred);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
        end else begin
            mism_q <= hit;
        end
    end

    assign mism = mism_q;

    prbs_err_div3 div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tap_chg),
        .hit_i   (hit),
        .event_o (err_event),
        .pulse_o (err_pulse)
    );

    prbs_sat_cnt #(.W(CNT_W)) bits_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (bit_vld),
        .cnt_o (bit_cnt)
    );

    prbs_sat_cnt #(.W(CNT_W)) errs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (err_event),
        .cnt_o (err_cnt)
    );

    AST_MISM_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mism |-> $past(bit_vld));  // R2

    AST_PULSE_WITH_MISM: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> mism);  // R4

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (bit_cnt == '0 && err_cnt == '0));  // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !mism);  // R9

endmodule

// File: tb/prbs_err_detector_tb_top.sv
module prbs_err_detector_tb_top;

    localparam int SW = 6;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, bit_vld, bit_in, cnt_clr;
    logic [4:0]  tap_a, tap_b;
    logic        mism, err_pulse;
    logic [31:0] bit_cnt, err_cnt;

    logic        s_vld, s_bit, s_clr;
    logic [4:0]  s_ta, s_tb;
    logic        s_mism, s_pulse;
    logic [SW-1:0] s_bcnt, s_ecnt;

    prbs_err_detector dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .tap_a(tap_a), .tap_b(tap_b), .cnt_clr(cnt_clr),
        .mism(mism), .err_pulse(err_pulse), .bit_cnt(bit_cnt), .err_cnt(err_cnt)
    );

    prbs_err_detector #(.CNT_W(SW)) sat_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(s_vld), .bit_in(s_bit),
        .tap_a(s_ta), .tap_b(s_tb), .cnt_clr(s_clr),
        .mism(s_mism), .err_pulse(s_pulse), .bit_cnt(s_bcnt), .err_cnt(s_ecnt)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Bench model state.
    logic [23:0] m_hist;
    int          m_fill, m_div, m_ta, m_tb;
    logic [31:0] m_bcnt, m_ecnt;
    logic [23:0] g_hist;
    int          n_mism, n_pulse;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampt(input int t);
        if (t == 0) return 1;
        if (t > 24) return 24;
        return t;
    endfunction

    function automatic logic gen_bit(input int ta, input int tb);
        logic b;
        b = g_hist[ta-1] ^ g_hist[tb-1];
        g_hist = {g_hist[22:0], b};
        return b;
    endfunction

    // One strobe; starts and ends at a falling edge.
    task automatic send_bit(input logic b, input logic clr);
        logic pred, em, ep;
        pred = m_hist[clampt(m_ta)-1] ^ m_hist[clampt(m_tb)-1];
        em = (m_fill >= 24) && (b ^ pred);
        ep = em && (m_div == 2);
        if (em) m_div = (m_div + 1) % 3;
        if (m_fill < 24) m_fill++;
        m_hist = {m_hist[22:0], b};
        if (clr) m_bcnt = 0; else if (m_bcnt != 32'hFFFF_FFFF) m_bcnt++;
        if (clr) m_ecnt = 0; else if (ep && m_ecnt != 32'hFFFF_FFFF) m_ecnt++;
        bit_vld = 1'b1; bit_in = b; cnt_clr = clr;
        @(negedge clk);
        bit_vld = 1'b0; cnt_clr = 1'b0;
        if (mism) n_mism++;
        if (err_pulse) n_pulse++;
        chk(mism === em, "R2", "mism", mism, em);
        chk(err_pulse === ep, "R4", "err_pulse", err_pulse, ep);
        chk(bit_cnt === m_bcnt, "R6", "bit_cnt", bit_cnt, m_bcnt);
        chk(err_cnt === m_ecnt, "R7", "err_cnt", err_cnt, m_ecnt);
    endtask

    task automatic set_taps(input int a, input int b);
        if (a != m_ta || b != m_tb) begin
            m_fill = 0; m_div = 0;
        end
        m_ta = a; m_tb = b;
        tap_a = 5'(a); tap_b = 5'(b);
        @(negedge clk);
        chk(mism === 1'b0, "R3", "mism on tap change", mism, 0);
    endtask

    task automatic t_reset();
        chk(mism === 1'b0 && err_pulse === 1'b0, "R1", "flags after reset",
            {mism, err_pulse}, 0);
        chk(bit_cnt === 0 && err_cnt === 0, "R1", "counters after reset",
            bit_cnt + err_cnt, 0);
    endtask

    task automatic t_fill();
        logic pred;
        n_mism = 0;
        for (int i = 0; i < 24; i++) send_bit(1'b1 ^ logic'(i % 3 == 0), 1'b0);
        chk(n_mism == 0, "R3", "mismatches during fill", n_mism, 0);
        pred = m_hist[m_ta-1] ^ m_hist[m_tb-1];
        send_bit(~pred, 1'b0);
        chk(mism === 1'b1, "R3", "25th bit compared", mism, 1);
    endtask

    task automatic t_clean();
        set_taps(11, 9);
        g_hist = 24'h5A3C1E;
        for (int i = 0; i < 24; i++) send_bit(gen_bit(11, 9), 1'b0);
        n_mism = 0;
        for (int i = 0; i < 200; i++) send_bit(gen_bit(11, 9), 1'b0);
        chk(n_mism == 0, "R10", "locked stream mismatches", n_mism, 0);
    endtask

    task automatic t_single();
        logic [31:0] e0;
        e0 = err_cnt; n_mism = 0; n_pulse = 0;
        send_bit(gen_bit(11, 9) ^ 1'b1, 1'b0);
        for (int i = 0; i < 30; i++) send_bit(gen_bit(11, 9), 1'b0);
        chk(n_mism == 3, "R4", "mismatches per error", n_mism, 3);
        chk(n_pulse == 1, "R4", "pulses per error", n_pulse, 1);
        chk(err_cnt == e0 + 1, "R4", "err_cnt step", err_cnt, e0 + 1);
    endtask

    task automatic t_double();
        n_pulse = 0;
        for (int k = 0; k < 2; k++) begin
            send_bit(gen_bit(11, 9) ^ 1'b1, 1'b0);
            for (int i = 0; i < 40; i++) send_bit(gen_bit(11, 9), 1'b0);
        end
        chk(n_pulse == 2, "R4", "pulses for two errors", n_pulse, 2);
    endtask

    task automatic t_tapchg();
        logic [31:0] e0;
        send_bit(gen_bit(11, 9) ^ 1'b1, 1'b0);
        send_bit(gen_bit(11, 9), 1'b0);
        send_bit(gen_bit(11, 9), 1'b0);
        set_taps(15, 14);
        for (int i = 0; i < 40; i++) send_bit(gen_bit(15, 14), 1'b0);
        e0 = err_cnt; n_mism = 0; n_pulse = 0;
        send_bit(gen_bit(15, 14) ^ 1'b1, 1'b0);
        for (int i = 0; i < 14; i++) send_bit(gen_bit(15, 14), 1'b0);
        chk(n_mism == 2 && n_pulse == 0, "R5", "no early pulse after tap change",
            n_pulse, 0);
        send_bit(gen_bit(15, 14), 1'b0);
        chk(err_pulse === 1'b1, "R5", "pulse on third mismatch", err_pulse, 1);
        chk(err_cnt == e0 + 1, "R5", "err_cnt after tap change", err_cnt, e0 + 1);
    endtask

    task automatic t_clamp();
        set_taps(0, 30);
        for (int i = 0; i < 60; i++) send_bit(gen_bit(1, 24), 1'b0);
        n_mism = 0;
        send_bit(gen_bit(1, 24) ^ 1'b1, 1'b0);
        for (int i = 0; i < 30; i++) send_bit(gen_bit(1, 24), 1'b0);
        chk(n_mism == 3, "R2", "clamped taps mismatches", n_mism, 3);
    endtask

    task automatic t_clear();
        // Third mismatch lands 24 strobes after the bad bit, on a clear.
        send_bit(gen_bit(1, 24) ^ 1'b1, 1'b0);
        for (int i = 0; i < 23; i++) send_bit(gen_bit(1, 24), 1'b0);
        send_bit(gen_bit(1, 24), 1'b1);
        chk(err_pulse === 1'b1, "R8", "pulse kept under clear", err_pulse, 1);
        chk(bit_cnt == 0 && err_cnt == 0, "R8", "clear beats increments",
            bit_cnt + err_cnt, 0);
        send_bit(gen_bit(1, 24), 1'b0);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        m_bcnt = 0; m_ecnt = 0;
        chk(bit_cnt == 0 && err_cnt == 0, "R8", "idle clear", bit_cnt + err_cnt, 0);
    endtask

    task automatic t_idle();
        logic [31:0] b0, e0;
        b0 = bit_cnt; e0 = err_cnt; n_mism = 0;
        for (int i = 0; i < 6; i++) begin
            bit_in = logic'(i % 2);
            @(negedge clk);
            if (mism) n_mism++;
        end
        chk(n_mism == 0, "R9", "mism without strobe", n_mism, 0);
        chk(bit_cnt == b0 && err_cnt == e0, "R9", "counters hold",
            bit_cnt, b0);
        n_mism = 0;
        for (int i = 0; i < 30; i++) send_bit(gen_bit(1, 24), 1'b0);
        chk(n_mism == 0, "R9", "history undisturbed", n_mism, 0);
    endtask

    task automatic t_sat();
        // Equal taps predict 0: every 1 after fill is a mismatch.
        for (int i = 0; i < 24; i++) begin
            s_vld = 1'b1; s_bit = 1'b0;
            @(negedge clk);
        end
        for (int i = 0; i < 200; i++) begin
            s_vld = 1'b1; s_bit = 1'b1;
            @(negedge clk);
        end
        s_vld = 1'b0;
        @(negedge clk);
        chk(s_bcnt == {SW{1'b1}}, "R6", "bit_cnt saturates", s_bcnt, 63);
        chk(s_ecnt == {SW{1'b1}}, "R7", "err_cnt saturates", s_ecnt, 63);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; cnt_clr = 1'b0;
        tap_a = 5'd9; tap_b = 5'd5;
        s_vld = 1'b0; s_bit = 1'b0; s_clr = 1'b0; s_ta = 5'd1; s_tb = 5'd1;
        m_hist = '0; m_fill = 0; m_div = 0; m_ta = 9; m_tb = 5;
        m_bcnt = 0; m_ecnt = 0; g_hist = 24'h1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_clean();
        t_single();
        t_double();
        t_tapchg();
        t_clamp();
        t_clear();
        t_idle();
        t_sat();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule